// File: doc/BRIEF.md
# SMBus Slave Protocol Engine

This block is the serial front end of a dual-channel power-switch controller. It watches the two-wire bus clock and data lines through synchronisers driven by a fast system clock. It detects start, repeated-start and stop conditions, decodes the 7-bit address and the direction bit, and pulls the data line low (open drain) to acknowledge and to send read data. A strap input selects which pair of channel addresses the block answers. It also answers a fixed alert-response address, but only for reads.

A write carries exactly one byte. That byte is presented on `wr_data`, with `wr_chan`, for one cycle on `wr_valid`. This happens only when a stop ends a write whose data byte was fully received and acknowledged. A read of a channel address returns the byte on `status_in`, captured at the moment `rd_strobe` pulses. A read of the alert-response address returns this device's channel-A address. The two output strobes have no ready signal. The bus cannot be stalled (clock stretching is not used), so the consumer must take each strobe in the cycle it is raised. A strobe is never repeated or held.

Top module: `smb_slave_engine`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid` and `rd_strobe` are all 0.
- R2: With `addr_strap`=0 the block acknowledges addresses 1010000 (channel A) and 1010001 (channel B) in either direction. With `addr_strap`=1 it acknowledges 1010010 (A) and 1010011 (B). Address bit 0 selects the channel. Any other address, apart from the one in R3, gets no acknowledge.
- R3: Address 0001100 is acknowledged only with the direction bit at 1 (read); a write to it gets no acknowledge. A read of it returns {the channel-A address for the current strap, 0}, MSB first.
- R4: After an address that is not acknowledged, `sda_oe` stays 0 and neither strobe pulses until the next start or stop.
- R5: In a write, the block acknowledges the address and then the data byte (MSB first). A following stop raises `wr_valid` for exactly one cycle with `wr_data` = the byte and `wr_chan` = address bit 0. `wr_valid` rises 3 clock cycles after the stop's SDA rising edge reaches the pin.
- R6: A stop or start that arrives before all 8 data bits have been received discards the partial byte; no `wr_valid` is produced.
- R7: A repeated start after a complete write byte discards that byte and begins a new address phase. A read then proceeds normally.
- R8: On an acknowledged read, `rd_strobe` pulses once, at the end of the address acknowledge. `rd_target` is 00 for channel A, 01 for channel B and 10 for the alert address. The byte returned is `status_in` as sampled in that cycle, MSB first.
- R9: If the master acknowledges a read byte, the same captured byte is sent again. If the master does not acknowledge, the block releases SDA and ignores traffic until the next start or stop.
- R10: `sda_oe` changes only while the synchronised SCL is low. An acknowledge or data bit appears on `sda_oe` 3 clock cycles after the SCL falling edge reaches the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 1 | Selects the channel address pair |
| status_in | input | 8 | Status byte returned on channel reads |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_valid | output | 1 | One-cycle pulse: a write byte is committed |
| wr_chan | output | 1 | Channel of the committed byte (0 = A, 1 = B) |
| wr_data | output | 8 | Committed write byte |
| rd_strobe | output | 1 | One-cycle pulse: a read byte was captured |
| rd_target | output | 2 | Read target: 00 A, 01 B, 10 alert address |

## Verification
Every result passes through the two synchroniser flops and then one output register. A pin edge is therefore seen by the edge detector two cycles after it arrives, and the register updates one cycle after that: `wr_valid` follows the stop by 3 cycles and `sda_oe` follows an SCL fall by 3 cycles. The bench changes the pins 1 ns after a rising edge, records the cycle number, and samples all outputs on falling edges. It checks those two latencies exactly. All other results are checked after the master has waited a full quarter bit (8 cycles), well past the 3-cycle delay. Data and acknowledge bits are read at the middle of SCL high, more than 16 cycles after the slave could have changed them.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK_WAIT,
    S_AACK,
    S_WDATA,
    S_DACK_WAIT,
    S_DACK,
    S_WHOLD,
    S_RDATA,
    S_RACK,
    S_RAGAIN,
    S_IGNORE
  } smb_state_t;

  localparam logic [1:0] TGT_CHA   = 2'b00;
  localparam logic [1:0] TGT_CHB   = 2'b01;
  localparam logic [1:0] TGT_ALERT = 2'b10;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] now,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign now[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= now;
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_held_high;
  assign scl_held_high = scl_s & scl_q;
  assign start_det = scl_held_high & sda_q & ~sda_s;
  assign stop_det  = scl_held_high & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/smb_addr_decode.sv
module smb_addr_decode #(
  parameter logic [6:0] CHAN_BASE  = 7'b1010000,
  parameter logic [6:0] ALERT_ADDR = 7'b0001100
) (
  input  logic       strap,
  input  logic [6:0] addr,
  input  logic       rw,
  output logic       hit,
  output logic [1:0] target,
  output logic [7:0] alert_byte
);
  import smb_pkg::*;
  logic [6:0] chan_a;
  logic       is_cha, is_chb, is_alert;

  assign chan_a   = {CHAN_BASE[6:2], strap, 1'b0};
  assign is_cha   = (addr == chan_a);
  assign is_chb   = (addr == {chan_a[6:1], 1'b1});
  assign is_alert = (addr == ALERT_ADDR);

  assign hit        = is_cha | is_chb | (is_alert & rw);
  assign target     = is_alert ? TGT_ALERT : (is_chb ? TGT_CHB : TGT_CHA);
  assign alert_byte = {chan_a, 1'b0};
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          hit,
  input  logic [1:0]    target_in,
  input  logic [DW-1:0] alert_byte,
  input  logic [DW-1:0] status_in,
  output logic [DW-2:0] dec_addr,
  output logic          dec_rw,
  output logic          sda_oe,
  output logic          wr_valid,
  output logic          wr_chan,
  output logic [DW-1:0] wr_data,
  output logic          rd_strobe,
  output logic [1:0]    rd_target
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  smb_state_t    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] hold;
  logic [DW-1:0] rd_pick;
  logic [DW-1:0] shifted;
  logic [1:0]    tgt;
  logic          is_rd;

  assign shifted  = {sh[DW-2:0], sda_s};
  assign dec_addr = shifted[DW-1:1];
  assign dec_rw   = shifted[0];
  assign rd_pick  = (tgt == TGT_ALERT) ? alert_byte : status_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      hold      <= '0;
      tgt       <= TGT_CHA;
      is_rd     <= 1'b0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_chan   <= 1'b0;
      wr_data   <= '0;
      rd_strobe <= 1'b0;
      rd_target <= TGT_CHA;
    end else begin
      wr_valid  <= 1'b0;
      rd_strobe <= 1'b0;
      if (start_det) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        if (state == S_WHOLD) begin
          wr_valid <= 1'b1;
          wr_chan  <= tgt[0];
          wr_data  <= sh;
        end
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            sh <= shifted;
            if (cnt == LAST) begin
              if (hit) begin
                state <= S_AACK_WAIT;
                tgt   <= target_in;
                is_rd <= dec_rw;
              end else begin
                state <= S_IGNORE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_AACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= S_AACK;
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (is_rd) begin
              sh        <= rd_pick;
              hold      <= rd_pick;
              sda_oe    <= ~rd_pick[DW-1];
              rd_strobe <= 1'b1;
              rd_target <= tgt;
              state     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WDATA;
            end
          end
          S_WDATA: if (scl_rise) begin
            sh <= shifted;
            if (cnt == LAST) state <= S_DACK_WAIT;
            else             cnt   <= cnt + 1'b1;
          end
          S_DACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= S_DACK;
          end
          S_DACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_WHOLD;
          end
          S_RDATA: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              sh     <= {sh[DW-2:0], 1'b0};
              sda_oe <= ~sh[DW-2];
              cnt    <= cnt + 1'b1;
            end
          end
          S_RACK: if (scl_rise) begin
            state <= sda_s ? S_IGNORE : S_RAGAIN;
          end
          S_RAGAIN: if (scl_fall) begin
            sh     <= hold;
            sda_oe <= ~hold[DW-1];
            cnt    <= '0;
            state  <= S_RDATA;
          end
          S_IDLE, S_WHOLD, S_IGNORE: ;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R10: the data line driver moves only while the clock line is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R5: a committed write always follows a detected stop
  p_wr_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(stop_det));

  // R5: the write strobe lasts a single cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R4: the slave keeps off the bus while ignoring traffic
  p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGNORE) |-> !sda_oe);

  // R8: a read capture happens on an SCL falling edge
  p_rd_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(scl_fall));
endmodule

// File: rtl/smb_slave_engine.sv
module smb_slave_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] CHAN_BASE   = 7'b1010000,
  parameter logic [6:0] ALERT_ADDR  = 7'b0001100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             addr_strap,
  input  logic [BYTE_W-1:0] status_in,
  output logic             sda_oe,
  output logic             wr_valid,
  output logic             wr_chan,
  output logic [BYTE_W-1:0] wr_data,
  output logic             rd_strobe,
  output logic [1:0]       rd_target
);
  logic [1:0] line_now, line_prev;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic hit;
  logic [1:0] target;
  logic [BYTE_W-1:0] alert_byte;
  logic [BYTE_W-2:0] dec_addr;
  logic dec_rw;

  smb_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({sda_in, scl_in}),
    .now  (line_now),
    .prev (line_prev)
  );

  smb_bus_events u_events (
    .scl_s    (line_now[0]),
    .scl_q    (line_prev[0]),
    .sda_s    (line_now[1]),
    .sda_q    (line_prev[1]),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  smb_addr_decode #(.CHAN_BASE(CHAN_BASE), .ALERT_ADDR(ALERT_ADDR)) u_decode (
    .strap     (addr_strap),
    .addr      (dec_addr),
    .rw        (dec_rw),
    .hit       (hit),
    .target    (target),
    .alert_byte(alert_byte)
  );

  smb_proto_fsm #(.DW(BYTE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_now[0]),
    .sda_s     (line_now[1]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .hit       (hit),
    .target_in (target),
    .alert_byte(alert_byte),
    .status_in (status_in),
    .dec_addr  (dec_addr),
    .dec_rw    (dec_rw),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_chan   (wr_chan),
    .wr_data   (wr_data),
    .rd_strobe (rd_strobe),
    .rd_target (rd_target)
  );
endmodule

// File: tb/smb_slave_engine_test.sv
`timescale 1ns/100ps
module smb_slave_engine_test;
  localparam int Q  = 8;
  localparam int NV = 12;
  // {strap, addr[6:0], rw, data[7:0], status[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 7'h50, 1'b0, 8'hA5, 8'h00},
    {1'b0, 7'h51, 1'b0, 8'h3C, 8'h00},
    {1'b0, 7'h52, 1'b0, 8'h0F, 8'h00},
    {1'b1, 7'h52, 1'b0, 8'h7E, 8'h00},
    {1'b1, 7'h53, 1'b0, 8'h81, 8'h00},
    {1'b0, 7'h0C, 1'b0, 8'h55, 8'h00},
    {1'b0, 7'h0C, 1'b1, 8'h00, 8'h99},
    {1'b1, 7'h0C, 1'b1, 8'h00, 8'h99},
    {1'b0, 7'h50, 1'b1, 8'h00, 8'h5A},
    {1'b1, 7'h53, 1'b1, 8'h00, 8'hC3},
    {1'b0, 7'h29, 1'b1, 8'hF0, 8'h11},
    {1'b1, 7'h50, 1'b1, 8'h00, 8'h22}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_strap = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic scl_in, sda_in;
  logic sda_oe, wr_valid, wr_chan, rd_strobe;
  logic [7:0] wr_data;
  logic [1:0] rd_target;

  assign scl_in = m_scl;
  assign sda_in = m_sda & ~sda_oe;

  smb_slave_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .addr_strap(addr_strap), .status_in(status_in), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_target(rd_target)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, bad10 = 0;
  int t_wr = 0, t_stop = 0, t_oe_rise = 0, t_fall = 0, t_f8 = 0;
  logic [7:0] wr_d = 8'h00;
  logic wr_c = 1'b0, oe_seen = 1'b0, oe_prev = 1'b0, scl_prev = 1'b1;
  logic [1:0] rd_t = 2'b00;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_valid) begin wr_cnt++; wr_d = wr_data; wr_c = wr_chan; t_wr = cyc; end
    if (rd_strobe) begin rd_cnt++; rd_t = rd_target; end
    if (sda_oe) oe_seen = 1'b1;
    if (sda_oe && !oe_prev) t_oe_rise = cyc;
    if ((sda_oe != oe_prev) && scl_in && scl_prev) bad10++;
    oe_prev = sda_oe;
    scl_prev = scl_in;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; t_fall = cyc; tick(Q);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; t_stop = cyc; tick(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    s = sda_in;   tick(Q);
    m_scl = 1'b0; t_fall = cyc; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    t_f8 = t_fall;
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); d[i] = s; end
    clock_bit(~mack, s);
  endtask

  function automatic logic exp_ack(input logic s, input logic [6:0] a, input logic rw);
    logic [6:0] ca;
    ca = {5'b10100, s, 1'b0};
    return (a == ca) || (a == {ca[6:1], 1'b1}) || (rw && a == 7'b0001100);
  endfunction

  initial begin : watchdog
    wait (cyc >= 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic s, rw, ack, ack2;
    logic [6:0] a;
    logic [7:0] d, st, rb, eb;
    int wr0, rd0;

    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 wr_valid after reset", wr_valid, 0);
    chk("R1 rd_strobe after reset", rd_strobe, 0);

    for (int v = 0; v < NV; v++) begin
      {s, a, rw, d, st} = VEC[v];
      addr_strap = s; status_in = st;
      tick(4);
      wr0 = wr_cnt; rd0 = rd_cnt;
      do_start;
      oe_seen = 1'b0;
      send_byte({a, rw}, ack);
      if (a == 7'b0001100) chk("R3 alert address ack", ack, exp_ack(s, a, rw));
      else                 chk("R2 address ack", ack, exp_ack(s, a, rw));
      if (!exp_ack(s, a, rw)) begin
        send_byte(d, ack2);
        do_stop; tick(Q);
        chk("R4 line untouched", oe_seen, 0);
        chk("R4 no strobes", (wr_cnt - wr0) + (rd_cnt - rd0), 0);
      end else if (!rw) begin
        send_byte(d, ack2);
        chk("R5 data ack", ack2, 1);
        do_stop; tick(Q);
        chk("R5 strobe count", wr_cnt - wr0, 1);
        chk("R5 data", wr_d, d);
        chk("R5 channel", wr_c, a[0]);
        chk("R5 stop latency", t_wr - t_stop, 3);
      end else begin
        recv_byte(rb, 1'b0);
        do_stop; tick(Q);
        if (a == 7'b0001100) begin
          eb = {5'b10100, s, 1'b0, 1'b0};
          chk("R3 alert read byte", rb, eb);
          chk("R8 alert target", rd_t, 2'b10);
        end else begin
          chk("R8 status byte", rb, st);
          chk("R8 channel target", rd_t, {1'b0, a[0]});
        end
        chk("R8 read strobe count", rd_cnt - rd0, 1);
      end
    end

    // R6: stop after 3 data bits
    addr_strap = 1'b0;
    wr0 = wr_cnt;
    do_start;
    send_byte({7'h50, 1'b0}, ack);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
    do_stop; tick(Q);
    chk("R6 early stop drops byte", wr_cnt - wr0, 0);

    // R6: restart after 5 data bits, then a full write
    wr0 = wr_cnt;
    do_start;
    send_byte({7'h50, 1'b0}, ack);
    for (int i = 0; i < 5; i++) clock_bit(1'b0, s);
    do_start;
    send_byte({7'h51, 1'b0}, ack);
    send_byte(8'h99, ack2);
    do_stop; tick(Q);
    chk("R6 one strobe after early start", wr_cnt - wr0, 1);
    chk("R6 data after early start", wr_d, 8'h99);
    chk("R6 channel after early start", wr_c, 1);

    // R7: full write then repeated start into a read; R10 ack latency
    wr0 = wr_cnt;
    status_in = 8'h3E;
    do_start;
    send_byte({7'h50, 1'b0}, ack);
    chk("R10 ack latency after SCL fall", t_oe_rise - t_f8, 3);
    send_byte(8'h11, ack2);
    do_start;
    send_byte({7'h50, 1'b1}, ack);
    chk("R7 read address acked", ack, 1);
    recv_byte(rb, 1'b0);
    do_stop; tick(Q);
    chk("R7 write byte dropped", wr_cnt - wr0, 0);
    chk("R7 read data", rb, 8'h3E);

    // R9: master ack repeats captured byte, nack releases
    status_in = 8'h6D;
    rd0 = rd_cnt;
    do_start;
    send_byte({7'h51, 1'b1}, ack);
    recv_byte(rb, 1'b1);
    chk("R9 first byte", rb, 8'h6D);
    status_in = 8'h00;
    recv_byte(rb, 1'b0);
    chk("R9 repeated byte", rb, 8'h6D);
    oe_seen = 1'b0;
    send_byte(8'h00, ack2);
    chk("R9 released after nack", oe_seen, 0);
    do_stop; tick(Q);
    chk("R9 single capture", rd_cnt - rd0, 1);

    chk("R10 no change while SCL high", bad10, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule